// File: doc/BRIEF.md
# Retention-Aware DRAM Refresh Scheduler

This block paces refresh commands for a group of DRAM banks. It lets rows that hold their data longer be refreshed less often. One scan is a base refresh window, and each scan visits every row address once. Each visited row is probed in two Bloom filters. The fast filter lists rows that need a refresh every window. The middle filter lists rows that need one every second window. A row found in neither filter falls back to one refresh every fourth window. A row found in both filters takes the fast rate. A Bloom filter can report a false positive but never a false negative, so a misclassified row is only refreshed more often than it needs.

A two-bit epoch counter advances at the end of every scan. Middle-rate and default-rate rows are matched to the epoch through their low row bits, which spreads their refreshes evenly over the windows. Commands leave on a valid/ready handshake. Two things gate the issue of a command: a short command-bus occupancy after each accepted command, and a longer per-bank occupancy. Filter contents are loaded between scans, one row key at a time, and can be wiped in a single cycle.

Top module: `retention_refresh_sched`

## Requirements
- R1: After reset `busy_o`, `cmd_valid_o`, `ref_cnt_o` and `epoch_o` are all zero.
- R2: A `win_tick_i` seen while idle starts a scan on the next cycle. The scan visits scan index 0 up to 2^KEY_W-1 in order, and index i maps to bank = i mod NBANKS and row = i / NBANKS. `busy_o` stays high until the last index is done. A `win_tick_i` seen while busy is ignored, and no command is offered while idle.
- R3: A row key is {bank, row}, with the bank field in the upper bits. An insert sets bit h1 and bit h2 of the chosen filter, and a probe hits only when both bits are set. h1 is the XOR of the key split into H_W-bit chunks, where H_W = log2(FILTER_BITS). h2 is bits [KEY_W-1:KEY_W-H_W] of (key × HMUL) mod 2^KEY_W.
- R4: A row that hits the fast filter (`flt_bin_i`=0) is refreshed in every window, whatever the middle filter reports.
- R5: A row that hits only the middle filter (`flt_bin_i`=1) is refreshed in a window only when epoch bit 0 equals row bit 0.
- R6: A row that hits neither filter is refreshed only when the epoch equals row bits [1:0].
- R7: While a command waits for `cmd_ready_i`, `cmd_valid_o` stays high, and `cmd_bank_o` and `cmd_row_o` do not change.
- R8: After an accepted command, no command is offered for the next CMD_CYC cycles.
- R9: After an accepted command, no command is offered to the same bank for the next BANK_CYC cycles.
- R10: Filter insert and clear are accepted only while idle. A clear zeroes both filters in one cycle and wins over an insert in the same cycle.
- R11: `ref_cnt_o` is cleared when a scan starts. It counts the commands accepted in that scan and holds its value while idle.
- R12: `epoch_o` advances by one, modulo 4, as each scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_tick_i | input | 1 | Base refresh window tick |
| flt_clr_i | input | 1 | Clear both filters |
| flt_ins_i | input | 1 | Insert `flt_key_i` into the filter chosen by `flt_bin_i` |
| flt_bin_i | input | 1 | 0 = fast bin, 1 = middle bin |
| flt_key_i | input | KEY_W | Row key {bank, row} to insert |
| cmd_valid_o | output | 1 | Refresh command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_bank_o | output | BANK_W | Target bank |
| cmd_row_o | output | ROW_W | Target row |
| busy_o | output | 1 | Scan in progress |
| epoch_o | output | 2 | Current window epoch |
| ref_cnt_o | output | CNT_W | Commands accepted in the current or last scan |

## Verification
The assertions run on every cycle. They check that a waiting command holds stable, that the command bus and each bank get their spacing, that no command is offered while idle, and that the counter and epoch step correctly at scan boundaries.

Rate selection cannot be shown that way. The bench must show that the right rows are refreshed in the right epochs, given the hashed filter contents, including double hits. It must also show that programming or ticks during a scan leave no trace, and that a clear wins over an insert. The bench's scenarios cover these with clean and stalling ready patterns, and they check each window's refresh count against a count worked out from the requirements.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} sched_st_e;
  typedef enum logic {BIN_FAST = 1'b0, BIN_MID = 1'b1} rate_bin_e;
  localparam int NUM_BINS = 2;
endpackage

// File: rtl/refsched_bloom.sv
module refsched_bloom #(
  parameter int KEY_W       = 6,
  parameter int FILTER_BITS = 16,
  parameter int HMUL        = 157
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ins_i,
  input  logic [KEY_W-1:0] ins_key_i,
  input  logic [KEY_W-1:0] probe_key_i,
  output logic             hit_o
);
  localparam int H_W = $clog2(FILTER_BITS);
  localparam int NCH = (KEY_W + H_W - 1) / H_W;
  localparam logic [KEY_W-1:0] HMUL_T = KEY_W'(HMUL);

  logic [FILTER_BITS-1:0] bits_q;

  function automatic logic [H_W-1:0] hash_fold(input logic [KEY_W-1:0] key);
    logic [NCH*H_W-1:0] pad;
    logic [H_W-1:0] h;
    pad = (NCH*H_W)'(key);
    h = '0;
    for (int c = 0; c < NCH; c++) h ^= pad[c*H_W +: H_W];
    return h;
  endfunction

  function automatic logic [H_W-1:0] hash_mul(input logic [KEY_W-1:0] key);
    logic [KEY_W-1:0] p;
    p = key * HMUL_T;
    return p[KEY_W-1 -: H_W];
  endfunction

  logic [H_W-1:0] ins_h1, ins_h2, prb_h1, prb_h2;
  assign ins_h1 = hash_fold(ins_key_i);
  assign ins_h2 = hash_mul(ins_key_i);
  assign prb_h1 = hash_fold(probe_key_i);
  assign prb_h2 = hash_mul(probe_key_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
    end else if (ins_i) begin
      bits_q[ins_h1] <= 1'b1;
      bits_q[ins_h2] <= 1'b1;
    end
  end

  assign hit_o = bits_q[prb_h1] & bits_q[prb_h2];
endmodule

// File: rtl/refsched_rate.sv
module refsched_rate (
  input  logic       hit_fast_i,
  input  logic       hit_mid_i,
  input  logic [1:0] epoch_i,
  input  logic [1:0] row_lo_i,
  output logic       need_o
);
  always_comb begin
    if (hit_fast_i)      need_o = 1'b1;
    else if (hit_mid_i)  need_o = (epoch_i[0] == row_lo_i[0]);
    else                 need_o = (epoch_i == row_lo_i);
  end
endmodule

// File: rtl/refsched_timers.sv
module refsched_timers #(
  parameter int BANK_W   = 2,
  parameter int CMD_CYC  = 1,
  parameter int BANK_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [BANK_W-1:0] fire_bank_i,
  output logic              bus_free_o,
  output logic [(1<<BANK_W)-1:0] bank_free_o
);
  localparam int NBANKS  = 1 << BANK_W;
  localparam int BUS_CW  = $clog2(CMD_CYC + 1);
  localparam int BANK_CW = $clog2(BANK_CYC + 1);

  logic [BUS_CW-1:0] bus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bus_q <= '0;
    else if (fire_i)          bus_q <= BUS_CW'(CMD_CYC);
    else if (bus_q != '0)     bus_q <= bus_q - 1'b1;
  end
  assign bus_free_o = (bus_q == '0);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [BANK_CW-1:0] occ_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   occ_q <= '0;
      else if (fire_i && fire_bank_i == BANK_W'(b))  occ_q <= BANK_CW'(BANK_CYC);
      else if (occ_q != '0)                          occ_q <= occ_q - 1'b1;
    end
    assign bank_free_o[b] = (occ_q == '0);
  end
endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched
  import refsched_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 4,
  parameter int FILTER_BITS = 16,
  parameter int HMUL        = 157,
  parameter int CMD_CYC     = 1,
  parameter int BANK_CYC    = 8,
  localparam int KEY_W      = BANK_W + ROW_W,
  localparam int CNT_W      = $clog2((1 << KEY_W) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_tick_i,
  input  logic              flt_clr_i,
  input  logic              flt_ins_i,
  input  logic              flt_bin_i,
  input  logic [KEY_W-1:0]  flt_key_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              busy_o,
  output logic [1:0]        epoch_o,
  output logic [CNT_W-1:0]  ref_cnt_o
);
  localparam int NBANKS = 1 << BANK_W;

  sched_st_e          st_q;
  logic [KEY_W-1:0]   idx_q;
  logic [1:0]         epoch_q;
  logic [CNT_W-1:0]   cnt_q;

  logic               scanning, idle, need, fire, advance, last_idx;
  logic               clr_en, ins_en, bus_free;
  logic [NBANKS-1:0]  bank_free;
  logic [BANK_W-1:0]  cur_bank;
  logic [ROW_W-1:0]   cur_row;
  logic [KEY_W-1:0]   probe_key;
  logic [NUM_BINS-1:0] bin_hit;

  assign scanning  = (st_q == ST_SCAN);
  assign idle      = ~scanning;
  // Bank in low index bits: consecutive probes alternate banks
  assign cur_bank  = idx_q[BANK_W-1:0];
  assign cur_row   = idx_q[KEY_W-1:BANK_W];
  assign probe_key = {cur_bank, cur_row};
  assign last_idx  = &idx_q;

  assign clr_en = idle & flt_clr_i;
  assign ins_en = idle & flt_ins_i & ~flt_clr_i;

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
    refsched_bloom #(
      .KEY_W(KEY_W), .FILTER_BITS(FILTER_BITS), .HMUL(HMUL)
    ) u_bloom (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr_en),
      .ins_i       (ins_en && (int'(flt_bin_i) == g)),
      .ins_key_i   (flt_key_i),
      .probe_key_i (probe_key),
      .hit_o       (bin_hit[g])
    );
  end

  refsched_rate u_rate (
    .hit_fast_i (bin_hit[BIN_FAST]),
    .hit_mid_i  (bin_hit[BIN_MID]),
    .epoch_i    (epoch_q),
    .row_lo_i   (cur_row[1:0]),
    .need_o     (need)
  );

  refsched_timers #(
    .BANK_W(BANK_W), .CMD_CYC(CMD_CYC), .BANK_CYC(BANK_CYC)
  ) u_timers (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .fire_bank_i (cur_bank),
    .bus_free_o  (bus_free),
    .bank_free_o (bank_free)
  );

  assign cmd_valid_o = scanning & need & bus_free & bank_free[cur_bank];
  assign fire        = cmd_valid_o & cmd_ready_i;
  assign advance     = scanning & (~need | fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      epoch_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (idle && win_tick_i) begin
        st_q  <= ST_SCAN;
        idx_q <= '0;
        cnt_q <= '0;
      end
      if (fire) cnt_q <= cnt_q + 1'b1;
      if (advance) begin
        idx_q <= idx_q + 1'b1;
        if (last_idx) begin
          st_q    <= ST_IDLE;
          epoch_q <= epoch_q + 1'b1;
        end
      end
    end
  end

  assign cmd_bank_o = cur_bank;
  assign cmd_row_o  = cur_row;
  assign busy_o     = scanning;
  assign epoch_o    = epoch_q;
  assign ref_cnt_o  = cnt_q;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 4,
  parameter int BANK_CYC = 8,
  parameter int CNT_W    = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [ROW_W-1:0]  cmd_row_o,
  input logic              busy_o,
  input logic [1:0]        epoch_o,
  input logic [CNT_W-1:0]  ref_cnt_o
);
  localparam int NBANKS = 1 << BANK_W;
  localparam int OCW    = $clog2(BANK_CYC + 1);

  logic [OCW-1:0] occ_q [NBANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBANKS; b++) occ_q[b] <= '0;
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (cmd_valid_o && cmd_ready_i && cmd_bank_o == BANK_W'(b)) occ_q[b] <= OCW'(BANK_CYC);
        else if (occ_q[b] != '0) occ_q[b] <= occ_q[b] - 1'b1;
      end
    end
  end

  AST_HOLD_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_bank_o) && $stable(cmd_row_o)); // R7
  AST_BUS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o); // R8
  AST_BANK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> occ_q[cmd_bank_o] == '0); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o); // R2
  AST_CNT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ref_cnt_o == '0); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> ref_cnt_o == $past(ref_cnt_o) + 1'b1); // R11
  AST_EPOCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> epoch_o == $past(epoch_o) + 2'd1); // R12
endmodule

bind retention_refresh_sched refsched_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .BANK_CYC(BANK_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_row_o   (cmd_row_o),
  .busy_o      (busy_o),
  .epoch_o     (epoch_o),
  .ref_cnt_o   (ref_cnt_o)
);

// File: tb/tb_retention_refresh_sched.sv
`timescale 1ns/1ps
module tb_retention_refresh_sched;
  localparam int BANK_W = 2, ROW_W = 4, KEY_W = 6, NROWS = 64, NBANKS = 4;
  localparam int FBITS = 16, HW = 4, HMUL = 157, CMD_CYC = 1, BANK_CYC = 8, CNT_W = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic win_tick_i = 0, flt_clr_i = 0, flt_ins_i = 0, flt_bin_i = 0, cmd_ready_i = 0;
  logic [KEY_W-1:0]  flt_key_i = '0;
  logic              cmd_valid_o, busy_o;
  logic [BANK_W-1:0] cmd_bank_o;
  logic [ROW_W-1:0]  cmd_row_o;
  logic [1:0]        epoch_o;
  logic [CNT_W-1:0]  ref_cnt_o;

  retention_refresh_sched #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .FILTER_BITS(FBITS), .HMUL(HMUL),
    .CMD_CYC(CMD_CYC), .BANK_CYC(BANK_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .win_tick_i(win_tick_i), .flt_clr_i(flt_clr_i),
    .flt_ins_i(flt_ins_i), .flt_bin_i(flt_bin_i), .flt_key_i(flt_key_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_bank_o(cmd_bank_o),
    .cmd_row_o(cmd_row_o), .busy_o(busy_o), .epoch_o(epoch_o), .ref_cnt_o(ref_cnt_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit fa [FBITS];
  bit fb [FBITS];
  int m_scan = 0, m_idx = 0, m_ep = 0, m_cnt = 0, m_bus = 0;
  int m_bank [NBANKS];
  int lf = 'hACE1;

  function automatic int hx1(int key);
    int r = 0;
    for (int c = 0; c < KEY_W; c += HW) r ^= (key >> c) & (FBITS - 1);
    return r;
  endfunction

  function automatic int hx2(int key);
    return ((key * HMUL) % NROWS) >> (KEY_W - HW);
  endfunction

  function automatic bit hit(int bin, int key);
    if (bin == 0) return fa[hx1(key)] && fa[hx2(key)];
    return fb[hx1(key)] && fb[hx2(key)];
  endfunction

  function automatic bit needs(int ep, int bank, int row);
    int key = (bank << ROW_W) | row;
    bit f = hit(0, key);
    bit m = hit(1, key);
    return f || (m && (ep % 2) == (row % 2)) || (!f && !m && ep == (row % 4));
  endfunction

  function automatic int exp_count(int ep);
    int n = 0;
    for (int k = 0; k < NROWS; k++) if (needs(ep, k % NBANKS, k / NBANKS)) n++;
    return n;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit tick, bit clr, bit ins, bit bin, int key, bit rdy);
    int bank, row;
    bit nd, ev, adv;
    win_tick_i = tick; flt_clr_i = clr; flt_ins_i = ins; flt_bin_i = bin;
    flt_key_i = KEY_W'(key); cmd_ready_i = rdy;
    #1;
    bank = m_idx % NBANKS;
    row  = m_idx / NBANKS;
    nd = (m_scan != 0) && needs(m_ep, bank, row);
    ev = nd && m_bus == 0 && m_bank[bank] == 0;
    chk(cmd_valid_o == ev, "R7/R8/R9 cmd_valid", int'(cmd_valid_o), int'(ev));
    if (ev && cmd_valid_o) begin
      chk(int'(cmd_bank_o) == bank, "R2 cmd_bank", int'(cmd_bank_o), bank);
      chk(int'(cmd_row_o) == row, "R2 cmd_row", int'(cmd_row_o), row);
    end
    chk(int'(busy_o) == m_scan, "R2 busy", int'(busy_o), m_scan);
    chk(int'(epoch_o) == m_ep, "R12 epoch", int'(epoch_o), m_ep);
    chk(int'(ref_cnt_o) == m_cnt, "R11 ref_cnt", int'(ref_cnt_o), m_cnt);
    for (int b = 0; b < NBANKS; b++) if (m_bank[b] > 0) m_bank[b]--;
    if (m_bus > 0) m_bus--;
    if (m_scan != 0) begin
      adv = 0;
      if (!nd) adv = 1;
      else if (ev && rdy) begin
        m_bus = CMD_CYC; m_bank[bank] = BANK_CYC; m_cnt++; adv = 1;
      end
      if (adv) begin
        if (m_idx == NROWS - 1) begin m_scan = 0; m_ep = (m_ep + 1) % 4; end
        else m_idx++;
      end
    end else begin
      if (clr) begin
        for (int i = 0; i < FBITS; i++) begin fa[i] = 0; fb[i] = 0; end
      end else if (ins) begin
        if (bin == 0) begin fa[hx1(key)] = 1; fa[hx2(key)] = 1; end
        else begin fb[hx1(key)] = 1; fb[hx2(key)] = 1; end
      end
      if (tick) begin m_scan = 1; m_idx = 0; m_cnt = 0; end
    end
    @(negedge clk);
  endtask

  // rmode 0: always ready, 1: pseudo-random ready; poke_at: index of an in-scan tick+insert
  task automatic run_window(int rmode, int poke_at);
    int expc;
    bit rdy, poked;
    expc = exp_count(m_ep);
    poked = 0;
    cyc(1, 0, 0, 0, 0, 1);
    while (m_scan != 0) begin
      rdy = (rmode == 0) ? 1'b1 : lf[0];
      lf = (lf >> 1) ^ ((lf & 1) ? 'hB400 : 0);
      if (!poked && m_idx == poke_at) begin
        poked = 1;
        cyc(1, 0, 1, 0, 33, rdy);  // R10 insert and R2 tick while busy: ignored
      end else begin
        cyc(0, 0, 0, 0, 0, rdy);
      end
    end
    cyc(0, 0, 0, 0, 0, 1);
    chk(int'(ref_cnt_o) == expc, "R3/R4/R5/R6 window count", int'(ref_cnt_o), expc);
  endtask

  initial begin
    for (int b = 0; b < NBANKS; b++) m_bank[b] = 0;
    for (int i = 0; i < FBITS; i++) begin fa[i] = 0; fb[i] = 0; end
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R1 busy", int'(busy_o), 0);
    chk(cmd_valid_o == 0, "R1 cmd_valid", int'(cmd_valid_o), 0);
    chk(ref_cnt_o == 0, "R1 ref_cnt", int'(ref_cnt_o), 0);
    chk(epoch_o == 0, "R1 epoch", int'(epoch_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    run_window(0, -1);
    chk(int'(ref_cnt_o) == NROWS / 4, "R6 default quarter", int'(ref_cnt_o), NROWS / 4);

    cyc(0, 0, 1, 0, 5, 1);
    cyc(0, 0, 1, 0, 40, 1);
    cyc(0, 0, 1, 1, 9, 1);
    cyc(0, 0, 1, 1, 22, 1);
    cyc(0, 0, 1, 1, 63, 1);
    cyc(0, 0, 1, 1, 5, 1);   // double hit: fast wins (R4)
    run_window(0, -1);
    run_window(1, 10);
    run_window(0, 27);
    run_window(1, -1);
    run_window(0, -1);

    cyc(1, 0, 1, 0, 17, 1);  // insert alongside a tick while idle
    while (m_scan != 0) cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);

    cyc(0, 1, 1, 0, 17, 1);  // R10 clear wins over insert
    run_window(1, -1);
    chk(int'(ref_cnt_o) == NROWS / 4, "R10 cleared filters", int'(ref_cnt_o), NROWS / 4);
    run_window(0, -1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule